// File: doc/BRIEF.md
# Framebuffer Control Register Interface

This block is the register slave of an 8-bit indexed-colour framebuffer controller. A processor reaches it through a request/response channel with byte addresses. The block decodes each word address into one of several regions and holds the contents of each. The regions are a 256-entry colour lookup table, a three-entry cursor colour table, a 512-slot cursor bitmap, and a few scalar registers: an identifier, a control word, a top-of-screen offset and a cursor position. The scan-out engine reads the tables through dedicated index/data ports and reads the scalars directly. It also receives a decoded pixel depth.

The stores and scalars are all 32-bit words, but the processor may write single bytes or halfwords. The block handles a narrow write by reading the word that the address currently reads back, replacing the addressed lane, and storing the merged word in the same cycle. The video timing window accepts writes and discards them. An address that belongs to no region completes normally and flags an error in its response. An interrupt line rises when the scan-out side reports a finished frame and falls on the next register write.

Both channels use valid/ready. A request transfers when `req_valid` and `req_ready` are both high. One response follows on the next cycle and stays, unchanged, on the response pins until `rsp_ready` is high. `req_ready` is low only while an unconsumed response is pending, so a stalled response stalls the request side.

Top module: `fbctl_regs`

## Requirements
- R1: A request transfers on a clock edge where req_valid and req_ready are both high. Its response appears with rsp_valid on the next cycle. req_ready equals (not rsp_valid) or rsp_ready. A response that is not taken keeps rsp_rdata and rsp_err unchanged.
- R2: While rst_n is low, every table entry and the control, top-of-screen and cursor-position registers clear to 0, and irq, rsp_valid and rsp_err are low.
- R3: Reading word offset 0x000000 returns 0x00000010. Writes to offset 0 and to the timing window 0x080000–0x0802FF have no effect. Reads in that window return 0. Neither sets rsp_err.
- R4: The control word (0x080300), top-of-screen (0x080400) and cursor position (0x080638) are 32-bit read/write registers, each visible on its own output pin.
- R5: pixel_depth follows control bits 22:20 through the map 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6→0, 7→0.
- R6: The colour table covers 0x080800–0x080FFF, and its entry index is address bits 10:3. A written word stores red from bits 23:16, green from 15:8 and blue from 7:0, which appear on pal_rgb in that order. Bus reads of this region return 0 without error, so a narrow write merges into zero.
- R7: The cursor colour table covers 0x080508–0x08051F, and its index is (address − 0x080508) >> 3, which gives three 8-byte slots. Both word offsets within a slot reach the same entry. Reads return the 24-bit colour with bits 31:24 zero. cpal_rgb reads 0 for cpal_idx 3.
- R8: The cursor bitmap covers 0x081000–0x081FFF, and its index is address bits 11:3. Each slot keeps bits 15:0 of the written word, and reads return them zero-extended.
- R9: req_size 0 writes wdata[7:0] into byte lane addr[1:0]. req_size 1 writes wdata[15:0] into the upper half if addr[1] is 1, and into the lower half otherwise. Sizes 2 and 3 write the whole word. The unaddressed lanes keep the value that the address reads back.
- R10: A request to any other address returns rdata 0 with rsp_err 1 in that response only, and a write there changes nothing.
- R11: A frame_done pulse sets irq on the next cycle. Any transferred write clears it. When both happen in the same cycle, irq is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 21 | Byte address in the register window |
| req_wdata | input | 32 | Write data, narrow data in the low bits |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Address mapped to no region |
| frame_done | input | 1 | One-cycle pulse at end of a frame |
| irq | output | 1 | Frame interrupt |
| ctrl_word | output | 32 | Control register |
| top_offset | output | 32 | Top-of-screen offset |
| cursor_pos | output | 32 | Cursor position |
| pixel_depth | output | 5 | Decoded bits per pixel |
| pal_idx | input | 8 | Colour table read index |
| pal_rgb | output | 24 | Colour table entry |
| cpal_idx | input | 2 | Cursor colour read index |
| cpal_rgb | output | 24 | Cursor colour entry |
| pat_idx | input | 9 | Cursor bitmap read index |
| pat_word | output | 16 | Cursor bitmap slot |

## Verification
A wrong region decode or slot index puts data into the wrong entry. That shows on the next cycle at a read port, or on the following bus read, as a value at an index that was never written. A broken lane merge corrupts only the untouched bytes, so narrow writes are checked against words that have distinct bytes. A register or irq state that is wrong after reset or a frame pulse is visible one cycle later on the plain output pins. Stalled responses are held for several cycles so that a lost or overwritten response shows as changed rsp_rdata.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_ID,
    RG_TIMING,
    RG_CTRL,
    RG_TOP,
    RG_CPOS,
    RG_CPAL,
    RG_PAL,
    RG_PAT
  } region_e;

  localparam logic [31:0] ID_VALUE     = 32'h0000_0010;
  localparam logic [31:0] OFS_ID       = 32'h0000_0000;
  localparam logic [31:0] OFS_TIM_LO   = 32'h0008_0000;
  localparam logic [31:0] OFS_TIM_HI   = 32'h0008_0300;
  localparam logic [31:0] OFS_CTRL     = 32'h0008_0300;
  localparam logic [31:0] OFS_TOP      = 32'h0008_0400;
  localparam logic [31:0] OFS_CPAL     = 32'h0008_0508;
  localparam logic [31:0] OFS_CPAL_END = 32'h0008_0520;
  localparam logic [31:0] OFS_CPOS     = 32'h0008_0638;
  localparam logic [31:0] OFS_PAL      = 32'h0008_0800;
  localparam logic [31:0] OFS_PAL_END  = 32'h0008_1000;
  localparam logic [31:0] OFS_PAT      = 32'h0008_1000;
  localparam logic [31:0] OFS_PAT_END  = 32'h0008_2000;

  localparam int SLOT_SHIFT = 3;

  function automatic logic [4:0] depth_of(input logic [2:0] sel);
    logic [4:0] d;
    case (sel)
      3'd0:    d = 5'd1;
      3'd1:    d = 5'd2;
      3'd2:    d = 5'd4;
      3'd3:    d = 5'd8;
      3'd4:    d = 5'd15;
      3'd5:    d = 5'd16;
      default: d = 5'd0;
    endcase
    return d;
  endfunction

  function automatic logic [31:0] merge_lanes(input logic [31:0] cur,
                                              input logic [31:0] nw,
                                              input logic [1:0]  size,
                                              input logic [1:0]  lane);
    logic [31:0] m;
    m = cur;
    case (size)
      2'd0: m[lane*8 +: 8] = nw[7:0];
      2'd1: begin
        if (lane[1]) m[31:16] = nw[15:0];
        else         m[15:0]  = nw[15:0];
      end
      default: m = nw;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
  import fbctl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SLOT_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [SLOT_W-1:0] slot
);
  logic [31:0] w;
  logic [31:0] rel;

  always_comb begin
    w      = {{(32-ADDR_W){1'b0}}, addr[ADDR_W-1:2], 2'b00};
    region = RG_NONE;
    rel    = '0;
    if (w == OFS_ID) begin
      region = RG_ID;
    end else if (w >= OFS_TIM_LO && w < OFS_TIM_HI) begin
      region = RG_TIMING;
    end else if (w == OFS_CTRL) begin
      region = RG_CTRL;
    end else if (w == OFS_TOP) begin
      region = RG_TOP;
    end else if (w == OFS_CPOS) begin
      region = RG_CPOS;
    end else if (w >= OFS_CPAL && w < OFS_CPAL_END) begin
      region = RG_CPAL;
      rel    = w - OFS_CPAL;
    end else if (w >= OFS_PAL && w < OFS_PAL_END) begin
      region = RG_PAL;
      rel    = w - OFS_PAL;
    end else if (w >= OFS_PAT && w < OFS_PAT_END) begin
      region = RG_PAT;
      rel    = w - OFS_PAT;
    end
    slot = rel[SLOT_SHIFT +: SLOT_W];
  end

endmodule

// File: rtl/fbctl_store.sv
module fbctl_store #(
  parameter int W     = 24,
  parameter int DEPTH = 256,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [W-1:0]  bus_rdata,
  input  logic [AW-1:0] port_raddr,
  output logic [W-1:0]  port_rdata
);
  logic [W-1:0] mem [DEPTH];
  logic w_ok, b_ok, p_ok;

  generate
    if (DEPTH == (1 << AW)) begin : g_full
      assign w_ok = 1'b1;
      assign b_ok = 1'b1;
      assign p_ok = 1'b1;
    end else begin : g_part
      assign w_ok = waddr      < AW'(DEPTH);
      assign b_ok = bus_raddr  < AW'(DEPTH);
      assign p_ok = port_raddr < AW'(DEPTH);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && w_ok) begin
      mem[waddr] <= wdata;
    end
  end

  assign bus_rdata  = b_ok ? mem[bus_raddr]  : '0;
  assign port_rdata = p_ok ? mem[port_raddr] : '0;

endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
  import fbctl_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 32,
  parameter int PAL_N   = 256,
  parameter int CPAL_N  = 3,
  parameter int PAT_N   = 512,
  parameter int RGB_W   = 24,
  parameter int PAT_W   = 16,
  localparam int PAL_AW  = $clog2(PAL_N),
  localparam int CPAL_AW = $clog2(CPAL_N + 1),
  localparam int PAT_AW  = $clog2(PAT_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  input  logic               frame_done,
  output logic               irq,
  output logic [DATA_W-1:0]  ctrl_word,
  output logic [DATA_W-1:0]  top_offset,
  output logic [DATA_W-1:0]  cursor_pos,
  output logic [4:0]         pixel_depth,
  input  logic [PAL_AW-1:0]  pal_idx,
  output logic [RGB_W-1:0]   pal_rgb,
  input  logic [CPAL_AW-1:0] cpal_idx,
  output logic [RGB_W-1:0]   cpal_rgb,
  input  logic [PAT_AW-1:0]  pat_idx,
  output logic [PAT_W-1:0]   pat_word
);
  region_e            region;
  logic [PAT_AW-1:0]  slot;
  logic               accept, wr_acc;
  logic [DATA_W-1:0]  cur_val, new_val;
  logic [DATA_W-1:0]  ctrl_q, top_q, cpos_q;
  logic [RGB_W-1:0]   cpal_bus, pal_bus;
  logic [PAT_W-1:0]   pat_bus;

  fbctl_decode #(.ADDR_W(ADDR_W), .SLOT_W(PAT_AW)) u_dec (
    .addr   (req_addr),
    .region (region),
    .slot   (slot)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;

  // value the addressed word reads back; also the base for narrow writes
  always_comb begin
    case (region)
      RG_ID:   cur_val = ID_VALUE;
      RG_CTRL: cur_val = ctrl_q;
      RG_TOP:  cur_val = top_q;
      RG_CPOS: cur_val = cpos_q;
      RG_CPAL: cur_val = DATA_W'(cpal_bus);
      RG_PAT:  cur_val = DATA_W'(pat_bus);
      default: cur_val = '0;
    endcase
  end

  assign new_val = merge_lanes(cur_val, req_wdata, req_size, req_addr[1:0]);

  fbctl_store #(.W(RGB_W), .DEPTH(PAL_N), .AW(PAL_AW)) u_pal (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (wr_acc && region == RG_PAL),
    .waddr      (slot[PAL_AW-1:0]),
    .wdata      (new_val[RGB_W-1:0]),
    .bus_raddr  (slot[PAL_AW-1:0]),
    .bus_rdata  (pal_bus),
    .port_raddr (pal_idx),
    .port_rdata (pal_rgb)
  );

  fbctl_store #(.W(RGB_W), .DEPTH(CPAL_N), .AW(CPAL_AW)) u_cpal (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (wr_acc && region == RG_CPAL),
    .waddr      (slot[CPAL_AW-1:0]),
    .wdata      (new_val[RGB_W-1:0]),
    .bus_raddr  (slot[CPAL_AW-1:0]),
    .bus_rdata  (cpal_bus),
    .port_raddr (cpal_idx),
    .port_rdata (cpal_rgb)
  );

  fbctl_store #(.W(PAT_W), .DEPTH(PAT_N), .AW(PAT_AW)) u_pat (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (wr_acc && region == RG_PAT),
    .waddr      (slot),
    .wdata      (new_val[PAT_W-1:0]),
    .bus_raddr  (slot),
    .bus_rdata  (pat_bus),
    .port_raddr (pat_idx),
    .port_rdata (pat_word)
  );

  // colour table is write-only from the bus; pal_bus kept for symmetry of the store
  logic pal_bus_unused;
  assign pal_bus_unused = ^pal_bus;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      top_q  <= '0;
      cpos_q <= '0;
    end else if (wr_acc) begin
      case (region)
        RG_CTRL: ctrl_q <= new_val;
        RG_TOP:  top_q  <= new_val;
        RG_CPOS: cpos_q <= new_val;
        default: ;
      endcase
    end
  end

  assign ctrl_word   = ctrl_q;
  assign top_offset  = top_q;
  assign cursor_pos  = cpos_q;
  assign pixel_depth = depth_of(ctrl_q[22:20]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : cur_val;
      rsp_err   <= (region == RG_NONE);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          irq <= 1'b0;
    else if (frame_done) irq <= 1'b1;
    else if (wr_acc)     irq <= 1'b0;
  end

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_rsp_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  p_stall_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_ctrl_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(ctrl_word));

  p_depth_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_depth inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16});

  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq);

  p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !frame_done) |=> !irq);

endmodule

// File: tb/fbctl_regs_bench.sv
module fbctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = 2'd2;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        frame_done = 1'b0;
  logic        irq;
  logic [31:0] ctrl_word, top_offset, cursor_pos;
  logic [4:0]  pixel_depth;
  logic [7:0]  pal_idx = '0;
  logic [23:0] pal_rgb;
  logic [1:0]  cpal_idx = '0;
  logic [23:0] cpal_rgb;
  logic [8:0]  pat_idx = '0;
  logic [15:0] pat_word;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fbctl_regs u_fbctl_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .frame_done(frame_done), .irq(irq),
    .ctrl_word(ctrl_word), .top_offset(top_offset), .cursor_pos(cursor_pos),
    .pixel_depth(pixel_depth), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
    .cpal_idx(cpal_idx), .cpal_rgb(cpal_rgb), .pat_idx(pat_idx), .pat_word(pat_word)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [20:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd2, 21'h000000, 32'h0,          32'h10,         1'b0, 4'd3},  // R3 id
    '{1'b1, 2'd2, 21'h000000, 32'h0000FFFF,   32'h0,          1'b0, 4'd3},  // R3
    '{1'b0, 2'd2, 21'h000000, 32'h0,          32'h10,         1'b0, 4'd3},  // R3
    '{1'b1, 2'd2, 21'h080118, 32'h00001234,   32'h0,          1'b0, 4'd3},  // R3 timing
    '{1'b0, 2'd2, 21'h080118, 32'h0,          32'h0,          1'b0, 4'd3},  // R3
    '{1'b1, 2'd2, 21'h080300, 32'h00300000,   32'h0,          1'b0, 4'd4},  // R4 ctrl
    '{1'b0, 2'd2, 21'h080300, 32'h0,          32'h00300000,   1'b0, 4'd4},  // R4
    '{1'b1, 2'd2, 21'h080400, 32'h00012345,   32'h0,          1'b0, 4'd4},  // R4 top
    '{1'b0, 2'd2, 21'h080400, 32'h0,          32'h00012345,   1'b0, 4'd4},  // R4
    '{1'b1, 2'd2, 21'h080638, 32'h00ABC123,   32'h0,          1'b0, 4'd4},  // R4 cpos
    '{1'b0, 2'd2, 21'h080638, 32'h0,          32'h00ABC123,   1'b0, 4'd4},  // R4
    '{1'b1, 2'd2, 21'h080510, 32'hAA112233,   32'h0,          1'b0, 4'd7},  // R7 slot 1
    '{1'b0, 2'd2, 21'h080510, 32'h0,          32'h00112233,   1'b0, 4'd7},  // R7
    '{1'b0, 2'd2, 21'h080514, 32'h0,          32'h00112233,   1'b0, 4'd7},  // R7 same slot
    '{1'b1, 2'd2, 21'h081FF8, 32'hDEADBEEF,   32'h0,          1'b0, 4'd8},  // R8 last slot
    '{1'b0, 2'd2, 21'h081FF8, 32'h0,          32'h0000BEEF,   1'b0, 4'd8},  // R8
    '{1'b1, 2'd0, 21'h080301, 32'h000000C4,   32'h0,          1'b0, 4'd9},  // R9 byte lane 1
    '{1'b0, 2'd2, 21'h080300, 32'h0,          32'h0030C400,   1'b0, 4'd9},  // R9
    '{1'b1, 2'd1, 21'h080402, 32'h0000BEEF,   32'h0,          1'b0, 4'd9},  // R9 upper half
    '{1'b0, 2'd2, 21'h080400, 32'h0,          32'hBEEF2345,   1'b0, 4'd9},  // R9
    '{1'b0, 2'd2, 21'h100000, 32'h0,          32'h0,          1'b1, 4'd10}, // R10 unmapped read
    '{1'b0, 2'd2, 21'h080808, 32'h0,          32'h0,          1'b0, 4'd6}   // R6 write-only read
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  logic [31:0] r_data;
  logic        r_err, r_vld;

  task automatic xact(input logic wr, input logic [1:0] sz, input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    r_vld = rsp_valid; r_data = rsp_rdata; r_err = rsp_err;
  endtask

  function automatic logic [4:0] exp_depth(input int s);
    case (s)
      0: return 5'd1;  1: return 5'd2;  2: return 5'd4;  3: return 5'd8;
      4: return 5'd15; 5: return 5'd16; default: return 5'd0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(irq == 0 && rsp_valid == 0 && rsp_err == 0, "R2 flags", {29'd0, irq, rsp_valid, rsp_err}, 0);
    chk(ctrl_word == 0 && top_offset == 0 && cursor_pos == 0, "R2 regs", ctrl_word | top_offset | cursor_pos, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready idle", {31'd0, req_ready}, 1);

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].wdata);
      chk(r_vld == 1, $sformatf("R1 vec%0d valid", i), {31'd0, r_vld}, 1);
      chk(r_data == VEC[i].exp, $sformatf("R%0d vec%0d data", VEC[i].req, i), r_data, VEC[i].exp);
      chk(r_err == VEC[i].err, $sformatf("R%0d vec%0d err", VEC[i].req, i), {31'd0, r_err}, {31'd0, VEC[i].err});
    end

    // R10 unmapped write: error flagged, registers untouched
    xact(1'b1, 2'd2, 21'h1FFFFC, 32'hFFFFFFFF);
    chk(r_err == 1, "R10 write err", {31'd0, r_err}, 1);
    chk(ctrl_word == 32'h0030C400 && top_offset == 32'hBEEF2345 && cursor_pos == 32'h00ABC123,
        "R10 no effect", ctrl_word, 32'h0030C400);
    @(negedge clk);
    chk(rsp_err == 0, "R10 err one response", {31'd0, rsp_err}, 0);

    // R9 cursor colour byte 3 dropped, byte 0 merged
    xact(1'b1, 2'd0, 21'h080513, 32'h00000077);
    cpal_idx = 2'd1; #1;
    chk(cpal_rgb == 24'h112233, "R9 cpal lane3", {8'd0, cpal_rgb}, 32'h112233);
    xact(1'b1, 2'd0, 21'h080510, 32'h00000099);
    chk(cpal_rgb == 24'h112299, "R9 cpal lane0", {8'd0, cpal_rgb}, 32'h112299);
    cpal_idx = 2'd3; #1;
    chk(cpal_rgb == 0, "R7 idx3", {8'd0, cpal_rgb}, 0);
    cpal_idx = 2'd0; #1;
    chk(cpal_rgb == 0, "R7 idx0 untouched", {8'd0, cpal_rgb}, 0);

    // R5 depth current then all codes
    chk(pixel_depth == 5'd8, "R5 depth from table run", {27'd0, pixel_depth}, 8);
    for (int s = 0; s < 8; s++) begin
      xact(1'b1, 2'd2, 21'h080300, 32'(s) << 20);
      chk(pixel_depth == exp_depth(s), $sformatf("R5 code %0d", s), {27'd0, pixel_depth}, {27'd0, exp_depth(s)});
    end

    // R6 colour table through the port
    xact(1'b1, 2'd2, 21'h080808, 32'hFFA1B2C3);
    xact(1'b1, 2'd2, 21'h080FF8, 32'h00123456);
    xact(1'b1, 2'd0, 21'h080802, 32'h00000055);
    pal_idx = 8'd1; #1;
    chk(pal_rgb == 24'hA1B2C3, "R6 idx1", {8'd0, pal_rgb}, 32'hA1B2C3);
    pal_idx = 8'd255; #1;
    chk(pal_rgb == 24'h123456, "R6 idx255", {8'd0, pal_rgb}, 32'h123456);
    pal_idx = 8'd0; #1;
    chk(pal_rgb == 24'h550000, "R6 narrow merges zero", {8'd0, pal_rgb}, 32'h550000);

    // R8 bitmap port
    pat_idx = 9'd511; #1;
    chk(pat_word == 16'hBEEF, "R8 port", {16'd0, pat_word}, 32'hBEEF);
    pat_idx = 9'd0; #1;
    chk(pat_word == 16'h0, "R8 other slot", {16'd0, pat_word}, 0);

    // R11 interrupt
    @(negedge clk); frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    chk(irq == 1, "R11 set", {31'd0, irq}, 1);
    xact(1'b0, 2'd2, 21'h080300, 32'h0);
    chk(irq == 1, "R11 read keeps", {31'd0, irq}, 1);
    xact(1'b1, 2'd2, 21'h080118, 32'h1);
    chk(irq == 0, "R11 write clears", {31'd0, irq}, 0);
    @(negedge clk);
    frame_done = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h080400; req_wdata = 32'h5;
    @(negedge clk);
    frame_done = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    chk(irq == 1, "R11 frame wins", {31'd0, irq}, 1);

    // R1 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 21'h080638;
    @(negedge clk);
    req_addr = 21'h080400;
    chk(rsp_valid == 1 && req_ready == 0, "R1 stall", {30'd0, rsp_valid, req_ready}, 2);
    repeat (3) @(negedge clk);
    chk(rsp_rdata == 32'h00ABC123, "R1 held data", rsp_rdata, 32'h00ABC123);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1 && rsp_rdata == 32'h5, "R1 second after release", rsp_rdata, 32'h5);
    @(negedge clk);
    chk(rsp_valid == 0, "R1 drained", {31'd0, rsp_valid}, 0);

    // R2 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    pal_idx = 8'd1; pat_idx = 9'd511; cpal_idx = 2'd1; #1;
    chk(pal_rgb == 0 && pat_word == 0 && cpal_rgb == 0, "R2 tables", {8'd0, pal_rgb | cpal_rgb}, 0);
    chk(irq == 0 && ctrl_word == 0 && top_offset == 0 && cursor_pos == 0, "R2 regs again",
        ctrl_word | top_offset | cursor_pos, 0);
    chk(pixel_depth == 5'd1, "R5 depth after reset", {27'd0, pixel_depth}, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule